// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor-side word port and a memory port that moves whole blocks. A byte address is split into three fields: a word offset inside the block, a set index, and a tag. Each of the 16 sets holds two ways. Each way keeps a tag, a valid flag, a dirty flag and a four-word block. Each set also keeps one bit that names the way to replace next.

A read hit returns its data in the cycle after the request is accepted. A miss first picks a victim way. An empty way is always chosen over an occupied one; otherwise the least recently used way is chosen. In write-back mode, a modified victim is copied to memory before the new block is fetched.

A build-time parameter selects the write policy. With `WRITE_BACK=1`, stores stay in the cache until the line is evicted, and a store miss allocates a line. With `WRITE_BACK=0`, every store is sent to memory at once as a single-word masked write, and a store miss leaves the cache untouched.

Top module: `assoc2_cache`

## Requirements
- R1: Address bits [3:2] select the 32-bit word in a block, bits [7:4] select the set, and bits [31:8] form the tag. Every memory transfer uses a block-aligned address, with bits [3:0] equal to zero.
- R2: A lookup hits only if one way of the indexed set is valid and holds the address tag. A read hit raises `cpu_resp_valid` in the cycle after acceptance, returns the stored word, and makes no memory transfer.
- R3: A read miss fetches exactly one block from the aligned address of the request. It then responds with the requested word.
- R4: While a set has an empty way, a miss fills that empty way. Two blocks with different tags in one set are then both resident.
- R5: When both ways are valid, a miss replaces the way that was used less recently. Every hit and every fill counts as a use.
- R6: In write-back mode, a store hit updates only the cache. It completes one cycle after acceptance with no memory transfer, and a later read returns the new word.
- R7: In write-back mode, evicting a modified line first writes the whole block to memory at the victim's own address, with `mem_wmask` = 4'b1111. Evicting a clean line makes no memory write.
- R8: In write-back mode, a store miss reads the block, merges the new word into it and keeps it in the cache. Memory is not written, and a later read of that word hits.
- R9: In write-through mode, a store hit updates the cached word. It also makes one memory write whose `mem_wmask` has only bit [offset] set, with the word repeated across all lanes of `mem_wblock`.
- R10: In write-through mode, a store miss writes the word to memory without reading or allocating a line, so a later read of that address misses.
- R11: `cpu_req_ready` is high only while idle. `cpu_resp_valid` is a single-cycle pulse. A memory request holds its address and direction until `mem_ack`.
- R12: After reset, every line is invalid, `cpu_req_ready` is high and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 32 | Load data, valid with the pulse |
| mem_req | output | 1 | Block transfer requested |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wmask | output | 4 | Word enables for a memory write |
| mem_wblock | output | 128 | Block write data, word 0 in the low bits |
| mem_ack | input | 1 | Transfer done; read block valid |
| mem_rblock | input | 128 | Block read data |

## Verification
The checker watches the handshake rules on every cycle. These rules are: no new request while busy, a single-cycle response pulse, memory requests held steady until acknowledged, aligned memory addresses, and a write mask that matches the selected policy. Only the directed scenarios can show the rest: which way is chosen as victim, the least-recently-used order, dirty write-back before refill, allocation or no allocation on a store miss, and the data values returned. The bench shows these by counting memory reads and writes, and by comparing returned words and memory contents with a shadow model.

// File: rtl/a2c_pkg.sv
package a2c_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int SETS     = 16;
    localparam int WORDS    = 4;
    localparam int WAYS     = 2;
    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int OFF_W    = $clog2(WORDS);
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W - BYTE_OFF;
    localparam int BLK_W    = DATA_W * WORDS;
    localparam int ALIGN_W  = OFF_W + BYTE_OFF;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t off;
    } afield_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOKUP, ST_WRITEBACK, ST_REFILL, ST_RESPOND
    } ctl_state_t;

    function automatic afield_t split_addr(input logic [ADDR_W-1:0] a);
        return afield_t'(a[ADDR_W-1:BYTE_OFF]);
    endfunction

    function automatic logic [ADDR_W-1:0] block_addr(input tag_t t, input idx_t i);
        return {t, i, {ALIGN_W{1'b0}}};
    endfunction

    function automatic blk_t merge_word(input blk_t b, input off_t o, input word_t w);
        blk_t r;
        r = b;
        r[o*DATA_W +: DATA_W] = w;
        return r;
    endfunction

    function automatic word_t pick_word(input blk_t b, input off_t o);
        return b[o*DATA_W +: DATA_W];
    endfunction
endpackage

// File: rtl/a2c_way.sv
module a2c_way
    import a2c_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  idx,
    input  tag_t  tag,
    output logic  hit,
    output logic  valid,
    output logic  dirty,
    output tag_t  tag_o,
    output blk_t  line_o,
    input  logic  fill_en,
    input  blk_t  fill_blk,
    input  logic  fill_dirty,
    input  logic  wr_en,
    input  off_t  wr_off,
    input  word_t wr_data,
    input  logic  wr_dirty
);
    logic [SETS-1:0] vld_q;
    logic [SETS-1:0] drt_q;
    tag_t            tag_q [SETS];
    blk_t            dat_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
        end else if (fill_en) begin
            vld_q[idx] <= 1'b1;
            drt_q[idx] <= fill_dirty;
        end else if (wr_en && wr_dirty) begin
            drt_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= tag;
            dat_q[idx] <= fill_blk;
        end else if (wr_en) begin
            dat_q[idx][wr_off*DATA_W +: DATA_W] <= wr_data;
        end
    end

    assign valid  = vld_q[idx];
    assign dirty  = drt_q[idx];
    assign tag_o  = tag_q[idx];
    assign line_o = dat_q[idx];
    assign hit    = vld_q[idx] && (tag_q[idx] == tag);
endmodule

// File: rtl/a2c_lru.sv
module a2c_lru
    import a2c_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t idx,
    output logic next_victim,
    input  logic touch_en,
    input  logic touch_way
);
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst)           lru_q <= '0;
        else if (touch_en) lru_q[idx] <= ~touch_way;
    end

    assign next_victim = lru_q[idx];
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
    import a2c_pkg::*;
#(
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORDS-1:0]  mem_wmask,
    output logic [BLK_W-1:0]  mem_wblock,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rblock
);
    ctl_state_t state_q, state_d;
    afield_t    af_q;
    logic       wr_q;
    word_t      wdata_q;
    logic       victim_q, evict_q;

    logic [WAYS-1:0] hit_v, valid_v, dirty_v, fill_v, wr_v;
    tag_t            tag_v  [WAYS];
    blk_t            line_v [WAYS];

    logic       any_hit, hit_way, lru_way, victim_c;
    logic       touch_en, touch_way;
    logic       unused_low;
    blk_t       fill_blk;
    logic [WORDS-1:0] word_sel;

    assign unused_low = ^cpu_req_addr[BYTE_OFF-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign fill_v[w] = (state_q == ST_REFILL) && mem_ack && (victim_q == w[0]);
        assign wr_v[w]   = (state_q == ST_LOOKUP) && hit_v[w] && wr_q;
        a2c_way u_way (
            .clk        (clk),
            .rst        (rst),
            .idx        (af_q.idx),
            .tag        (af_q.tag),
            .hit        (hit_v[w]),
            .valid      (valid_v[w]),
            .dirty      (dirty_v[w]),
            .tag_o      (tag_v[w]),
            .line_o     (line_v[w]),
            .fill_en    (fill_v[w]),
            .fill_blk   (fill_blk),
            .fill_dirty (WRITE_BACK && wr_q),
            .wr_en      (wr_v[w]),
            .wr_off     (af_q.off),
            .wr_data    (wdata_q),
            .wr_dirty   (WRITE_BACK)
        );
    end

    assign any_hit  = |hit_v;
    assign hit_way  = hit_v[1];
    assign victim_c = !valid_v[0] ? 1'b0 : (!valid_v[1] ? 1'b1 : lru_way);
    assign fill_blk = wr_q ? merge_word(mem_rblock, af_q.off, wdata_q) : mem_rblock;

    assign touch_en  = ((state_q == ST_LOOKUP) && any_hit) ||
                       ((state_q == ST_REFILL) && mem_ack);
    assign touch_way = (state_q == ST_REFILL) ? victim_q : hit_way;

    a2c_lru u_lru (
        .clk         (clk),
        .rst         (rst),
        .idx         (af_q.idx),
        .next_victim (lru_way),
        .touch_en    (touch_en),
        .touch_way   (touch_way)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (cpu_req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (wr_q && !WRITE_BACK)  state_d = ST_WRITEBACK;
                else if (any_hit)         state_d = ST_IDLE;
                else if (WRITE_BACK && valid_v[victim_c] && dirty_v[victim_c])
                                          state_d = ST_WRITEBACK;
                else                      state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (mem_ack) state_d = evict_q ? ST_REFILL : ST_RESPOND;
            ST_REFILL:    if (mem_ack) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            af_q     <= '0;
            wr_q     <= 1'b0;
            wdata_q  <= '0;
            victim_q <= 1'b0;
            evict_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req_valid) begin
                af_q    <= split_addr(cpu_req_addr);
                wr_q    <= cpu_req_write;
                wdata_q <= cpu_req_wdata;
            end
            if (state_q == ST_LOOKUP) begin
                victim_q <= victim_c;
                evict_q  <= !(wr_q && !WRITE_BACK) && !any_hit;
            end
        end
    end

    always_comb begin
        word_sel = '0;
        word_sel[af_q.off] = 1'b1;
    end

    assign cpu_req_ready  = (state_q == ST_IDLE);
    assign cpu_resp_valid = (state_q == ST_RESPOND) ||
                            ((state_q == ST_LOOKUP) && any_hit && !(wr_q && !WRITE_BACK));
    assign cpu_resp_rdata = pick_word(line_v[hit_way], af_q.off);

    assign mem_req    = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
    assign mem_we     = (state_q == ST_WRITEBACK);
    assign mem_addr   = (mem_we && evict_q) ? block_addr(tag_v[victim_q], af_q.idx)
                                            : block_addr(af_q.tag, af_q.idx);
    assign mem_wmask  = evict_q ? {WORDS{1'b1}} : word_sel;
    assign mem_wblock = evict_q ? line_v[victim_q] : {WORDS{wdata_q}};
endmodule

// File: rtl/assoc2_cache_chk.sv
module assoc2_cache_chk
    import a2c_pkg::*;
#(
    parameter bit WRITE_BACK = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORDS-1:0]  mem_wmask
);
    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |=> !cpu_resp_valid); // R11
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cpu_req_valid && cpu_req_ready |=> !cpu_req_ready); // R11
    AST_RESP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> !cpu_req_ready); // R11
    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[ALIGN_W-1:0] == '0)); // R1
    AST_WRITE_MASK_POLICY: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> (WRITE_BACK ? (&mem_wmask) : $onehot(mem_wmask))); // R7 R9
    AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> !mem_req); // R12
endmodule

bind assoc2_cache assoc2_cache_chk #(.WRITE_BACK(WRITE_BACK)) u_chk (.*);

// File: tb/sim_assoc2_cache.sv
module sim_assoc2_cache;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic         rq_v [2], rq_rdy [2], rq_w [2], rsp_v [2];
    logic [31:0]  rq_a [2], rq_d [2], rsp_d [2], m_addr [2];
    logic         m_req [2], m_we [2], m_ack [2];
    logic [3:0]   m_mask [2];
    logic [127:0] m_wblk [2], m_rblk [2];

    logic [31:0]  mem [2][512];
    logic [31:0]  shadow [2][512];
    int           rd_cnt [2], wr_cnt [2], lat [2];
    logic [31:0]  last_a [2];
    logic [3:0]   last_m [2];
    int           n_chk = 0, n_err = 0;

    assoc2_cache #(.WRITE_BACK(1'b1)) u0 (
        .clk(clk), .rst(rst), .cpu_req_valid(rq_v[0]), .cpu_req_ready(rq_rdy[0]),
        .cpu_req_write(rq_w[0]), .cpu_req_addr(rq_a[0]), .cpu_req_wdata(rq_d[0]),
        .cpu_resp_valid(rsp_v[0]), .cpu_resp_rdata(rsp_d[0]), .mem_req(m_req[0]),
        .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_wmask(m_mask[0]),
        .mem_wblock(m_wblk[0]), .mem_ack(m_ack[0]), .mem_rblock(m_rblk[0]));

    assoc2_cache #(.WRITE_BACK(1'b0)) u1 (
        .clk(clk), .rst(rst), .cpu_req_valid(rq_v[1]), .cpu_req_ready(rq_rdy[1]),
        .cpu_req_write(rq_w[1]), .cpu_req_addr(rq_a[1]), .cpu_req_wdata(rq_d[1]),
        .cpu_resp_valid(rsp_v[1]), .cpu_resp_rdata(rsp_d[1]), .mem_req(m_req[1]),
        .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_wmask(m_mask[1]),
        .mem_wblock(m_wblk[1]), .mem_ack(m_ack[1]), .mem_rblock(m_rblk[1]));

    // memory model: acknowledges three cycles after a request appears
    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                m_ack[d] <= 1'b0;
                lat[d]   <= 0;
            end else if (m_req[d] && !m_ack[d]) begin
                if (lat[d] == 2) begin
                    lat[d]   <= 0;
                    m_ack[d] <= 1'b1;
                    last_a[d] <= m_addr[d];
                    if (m_we[d]) begin
                        wr_cnt[d] <= wr_cnt[d] + 1;
                        last_m[d] <= m_mask[d];
                        for (int k = 0; k < 4; k++)
                            if (m_mask[d][k])
                                mem[d][m_addr[d][10:2] + 9'(k)] <= m_wblk[d][k*32 +: 32];
                    end else begin
                        rd_cnt[d] <= rd_cnt[d] + 1;
                        for (int k = 0; k < 4; k++)
                            m_rblk[d][k*32 +: 32] <= mem[d][m_addr[d][10:2] + 9'(k)];
                    end
                end else begin
                    lat[d] <= lat[d] + 1;
                end
            end else begin
                m_ack[d] <= 1'b0;
            end
        end
    end

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return {24'(tag), 4'(set), 2'(word), 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input int d, input logic we, input logic [31:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        rq_v[d] = 1'b1; rq_w[d] = we; rq_a[d] = a; rq_d[d] = wd;
        @(posedge clk);
        @(negedge clk);
        rq_v[d] = 1'b0;
        cyc = 1;
        while (!rsp_v[d] && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        rd = rsp_d[d];
        if (we) shadow[d][a[10:2]] = wd;
    endtask

    task automatic t_reset();
        for (int d = 0; d < 2; d++) begin
            chk("R12 ready after reset", 32'(rq_rdy[d]), 32'd1);
            chk("R12 no mem request after reset", 32'(m_req[d]), 32'd0);
        end
    endtask

    task automatic t_read_basic();
        logic [31:0] r; int c, r0;
        r0 = rd_cnt[0];
        access(0, 0, mk(1, 3, 2), 0, r, c);
        chk("R3 read miss data", r, shadow[0][mk(1, 3, 2) >> 2]);
        chk("R3 one block read", 32'(rd_cnt[0] - r0), 32'd1);
        chk("R1 aligned block address", last_a[0], mk(1, 3, 0));
        chk("R3 miss takes longer than one cycle", 32'(c > 1), 32'd1);
        access(0, 0, mk(1, 3, 2), 0, r, c);
        chk("R2 read hit latency", 32'(c), 32'd1);
        chk("R2 read hit data", r, shadow[0][mk(1, 3, 2) >> 2]);
        access(0, 0, mk(1, 3, 0), 0, r, c);
        chk("R1 other word same block hits", 32'(rd_cnt[0] - r0), 32'd1);
        chk("R1 offset selects word 0", r, shadow[0][mk(1, 3, 0) >> 2]);
    endtask

    task automatic t_ways_lru();
        logic [31:0] r; int c, r0, w0;
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 0, mk(2, 3, 1), 0, r, c);
        chk("R4 second tag fills empty way", 32'(rd_cnt[0] - r0), 32'd1);
        access(0, 0, mk(1, 3, 2), 0, r, c);
        chk("R4 first tag still resident", 32'(c), 32'd1);
        access(0, 0, mk(2, 3, 1), 0, r, c);
        chk("R4 second tag resident", 32'(c), 32'd1);
        access(0, 0, mk(1, 3, 2), 0, r, c);   // tag1 most recent, tag2 is LRU
        access(0, 0, mk(3, 3, 3), 0, r, c);
        chk("R5 third tag data", r, shadow[0][mk(3, 3, 3) >> 2]);
        chk("R7 clean victim not written", 32'(wr_cnt[0] - w0), 32'd0);
        access(0, 0, mk(1, 3, 2), 0, r, c);
        chk("R5 recently used tag kept", 32'(c), 32'd1);
        r0 = rd_cnt[0];
        access(0, 0, mk(2, 3, 1), 0, r, c);
        chk("R5 least recent tag was evicted", 32'(rd_cnt[0] - r0), 32'd1);
        access(0, 0, mk(1, 3, 2), 0, r, c);
        chk("R5 use keeps tag1 resident", 32'(c), 32'd1);
    endtask

    task automatic t_write_back();
        logic [31:0] r; int c, r0, w0;
        access(0, 0, mk(1, 5, 0), 0, r, c);
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 1, mk(1, 5, 0), 32'hDEAD_0001, r, c);
        chk("R6 write hit latency", 32'(c), 32'd1);
        chk("R6 write hit no memory write", 32'(wr_cnt[0] - w0), 32'd0);
        chk("R6 memory unchanged", mem[0][mk(1, 5, 0) >> 2], 32'h0000_0000 | (mk(1, 5, 0) >> 2));
        access(0, 0, mk(1, 5, 0), 0, r, c);
        chk("R6 read back new data", r, 32'hDEAD_0001);
        access(0, 0, mk(2, 5, 0), 0, r, c);
        access(0, 0, mk(3, 5, 0), 0, r, c);   // evicts dirty tag1
        chk("R7 dirty victim written once", 32'(wr_cnt[0] - w0), 32'd1);
        chk("R7 full block mask", 32'(last_m[0]), 32'hF);
        chk("R7 victim data in memory", mem[0][mk(1, 5, 0) >> 2], 32'hDEAD_0001);
        chk("R7 refill after write-back", last_a[0], mk(3, 5, 0));
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 1, mk(4, 5, 1), 32'hBEEF_0004, r, c);
        chk("R8 store miss reads block", 32'(rd_cnt[0] - r0), 32'd1);
        chk("R8 store miss no memory write", 32'(wr_cnt[0] - w0), 32'd0);
        chk("R8 memory not yet updated", mem[0][mk(4, 5, 1) >> 2], mk(4, 5, 1) >> 2);
        access(0, 0, mk(4, 5, 1), 0, r, c);
        chk("R8 allocated line hits", 32'(c), 32'd1);
        chk("R8 merged word", r, 32'hBEEF_0004);
        access(0, 0, mk(4, 5, 2), 0, r, c);
        chk("R8 rest of block from memory", r, shadow[0][mk(4, 5, 2) >> 2]);
    endtask

    task automatic t_write_through();
        logic [31:0] r; int c, r0, w0;
        access(1, 0, mk(1, 2, 3), 0, r, c);
        chk("R3 write-through read miss data", r, shadow[1][mk(1, 2, 3) >> 2]);
        r0 = rd_cnt[1]; w0 = wr_cnt[1];
        access(1, 1, mk(1, 2, 3), 32'h1234_5678, r, c);
        chk("R9 store hit writes memory", 32'(wr_cnt[1] - w0), 32'd1);
        chk("R9 single word mask", 32'(last_m[1]), 32'h8);
        chk("R9 memory word updated", mem[1][mk(1, 2, 3) >> 2], 32'h1234_5678);
        chk("R9 neighbour word intact", mem[1][mk(1, 2, 2) >> 2], 32'h0001_0000 | (mk(1, 2, 2) >> 2));
        access(1, 0, mk(1, 2, 3), 0, r, c);
        chk("R9 cached copy updated", r, 32'h1234_5678);
        chk("R9 read after store hits", 32'(c), 32'd1);
        access(1, 1, mk(5, 2, 1), 32'hCAFE_0005, r, c);
        chk("R10 store miss no block read", 32'(rd_cnt[1] - r0), 32'd0);
        chk("R10 store miss writes memory", mem[1][mk(5, 2, 1) >> 2], 32'hCAFE_0005);
        access(1, 0, mk(5, 2, 1), 0, r, c);
        chk("R10 no allocation, read misses", 32'(rd_cnt[1] - r0), 32'd1);
        chk("R10 data from memory", r, 32'hCAFE_0005);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        rq_v[0] = 1'b1; rq_w[0] = 1'b0; rq_a[0] = mk(6, 9, 0);
        @(posedge clk);
        @(negedge clk);
        rq_v[0] = 1'b0;
        chk("R11 not ready while busy", 32'(rq_rdy[0]), 32'd0);
        while (!rsp_v[0]) @(negedge clk);
        @(negedge clk);
        chk("R11 response is one pulse", 32'(rsp_v[0]), 32'd0);
        chk("R11 ready again", 32'(rq_rdy[0]), 32'd1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            rq_v[d] = 0; rq_w[d] = 0; rq_a[d] = 0; rq_d[d] = 0;
            rd_cnt[d] = 0; wr_cnt[d] = 0; last_a[d] = 0; last_m[d] = 0;
            m_rblk[d] = '0;
            for (int i = 0; i < 512; i++) begin
                mem[d][i]    = (32'(d) << 16) | 32'(i);
                shadow[d][i] = (32'(d) << 16) | 32'(i);
            end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_ways_lru();
        t_write_back();
        t_write_through();
        t_handshake();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule